// File: doc/BRIEF.md
# Relocatable Register-Map Address Decoder

This block watches the processor's bus cycles and decides whether each one addresses a peripheral's internal register group. The group spans 220 byte offsets (00h to DBh). Software can move its base at run time. After reset the group sits at the bottom of the 16-bit I/O space. Software can move it to any 256-byte boundary in I/O space, or switch it into the 32-bit memory space at any 16-Mbyte boundary.

Every slave access is one byte wide and uses byte lane 0 (bits 7:0) or byte lane 1 (bits 15:8). For each selected access the decoder gives the register file a chip-select, a byte offset, the lane in use and the write flag. It inserts its own wait states before it returns ready, so software never has to pad its accesses. The relocation state lives in two byte registers inside the decoder. Everything else in the group belongs to the register file downstream.

Top module: `relmap_decoder`

## Requirements
- R1: After reset `dec_cs` and `dec_rdy` are low, and the map is in I/O space with base 00h.
- R2: In I/O mode an I/O cycle (`bus_mio`=0) whose address bits 15:8 equal the base is selected. `dec_ofs` is then {A7:A1, lane}, so the lowest I/O addresses give offsets 00h through DBh. Address bits 31:16 play no part in an I/O decode.
- R3: An access whose offset is above DBh is never selected: `dec_cs` and `dec_rdy` stay low.
- R4: In I/O mode, memory cycles and I/O cycles whose bits 15:8 differ from the base are not selected.
- R5: In memory mode a memory cycle (`bus_mio`=1) is selected only when A31:A24 equal the base and A23:A8 are all zero. I/O cycles are not selected in this mode.
- R6: `bus_be` must have exactly one bit set. `bus_be`=01 selects lane 0: `dec_lane`=0 and the offset is even. `bus_be`=10 selects lane 1: `dec_lane`=1 and the offset is odd. A value of 00 or 11 is not selected.
- R7: On a selected access `dec_cs` rises in the cycle after the `bus_ads` edge and stays high through the ready cycle. After two wait cycles `dec_rdy` is high for exactly one cycle. `dec_ofs` holds steady throughout.
- R8: A write to offset 7Eh loads the base from data bits 7:0. A write to offset 7Fh loads the space select from data bits 15:8: 00h selects I/O, any nonzero value selects memory. The new value takes effect from the next bus cycle. The writing cycle itself is decoded against the old map.
- R9: A `bus_ads` pulse that arrives while a selected access is still in progress is ignored.
- R10: `dec_wr` equals the `bus_wr` value of the accepted access for as long as `dec_cs` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_ads | input | 1 | Address strobe, high for the first cycle of a bus cycle |
| bus_mio | input | 1 | Cycle space: 1 memory, 0 I/O |
| bus_wr | input | 1 | 1 write, 0 read |
| bus_addr | input | 31 | Address bits 31:1 |
| bus_be | input | 2 | Active-high byte enables for lanes 1:0 |
| bus_wdata | input | 16 | Write data on lanes 1:0 |
| dec_cs | output | 1 | Register group selected for the current access |
| dec_ofs | output | 8 | Byte offset inside the group |
| dec_lane | output | 1 | Byte lane of the access |
| dec_wr | output | 1 | Write flag of the current access |
| dec_rdy | output | 1 | Ready, one cycle, ends the access |

## Verification
The decode is tried with addresses at both ends of the default window and just past it (DAh/DBh against DCh/FFh). This separates the offset limit from the base compare. I/O cycles with noise in bits 31:16 and memory cycles with bits 23:8 set show which address fields each mode compares and which it ignores. Byte-enable patterns 01, 10, 00 and 11 separate lane steering from lane rejection. A sequence of relocations (new I/O base, then memory space, then back to I/O) shows that the old base stops answering, that the writing cycle still uses the old map, and that a strobe arriving mid-access does not restart the wait count.

// File: rtl/relmap_pkg.sv
// Package: shared types for the relocatable register-map decoder.
// Assumes an 8-bit register offset and a single space-select flag.
package relmap_pkg;

    typedef enum logic {
        SPACE_IO  = 1'b0,
        SPACE_MEM = 1'b1
    } space_e;

    // Captured attributes of an accepted slave access
    typedef struct packed {
        logic [7:0] ofs;
        logic       lane;
        logic       wr;
    } acc_t;

endpackage

// File: rtl/relmap_reloc_reg.sv
// Relocation state: base byte and space select.
// Assumes the load strobes fire only in the ready cycle of a write, so the
// new value is seen from the next bus cycle on. A nonzero space byte selects
// memory space.
module relmap_reloc_reg
    import relmap_pkg::*;
#(
    parameter int BASE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_base,
    input  logic              load_space,
    input  logic [BASE_W-1:0] wbyte,
    output logic [BASE_W-1:0] base,
    output space_e            space
);

    // Hold base and space; reset puts the map at I/O address 0
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base  <= '0;
            space <= SPACE_IO;
        end else begin
            if (load_base)  base  <= wbyte;
            if (load_space) space <= (wbyte != '0) ? SPACE_MEM : SPACE_IO;
        end
    end

endmodule

// File: rtl/relmap_addr_match.sv
// Combinational decode of the bus address against the current map.
// Assumes a 256-byte window per I/O base and a 16-Mbyte window per memory
// base. Only one byte lane may be enabled.
module relmap_addr_match
    import relmap_pkg::*;
#(
    parameter int          ADDR_W   = 32,
    parameter int          IO_W     = 16,
    parameter int          BASE_W   = 8,
    parameter int          OFS_W    = 8,
    parameter int          LANES    = 2,
    parameter logic [7:0]  BLK_LAST = 8'hDB
) (
    input  logic              bus_mio,
    input  logic [ADDR_W-1:1] bus_addr,
    input  logic [LANES-1:0]  bus_be,
    input  logic [BASE_W-1:0] base,
    input  space_e            space,
    output logic              hit,
    output logic [OFS_W-1:0]  ofs,
    output logic              lane
);

    localparam int IO_LO  = IO_W - BASE_W;
    localparam int MEM_LO = ADDR_W - BASE_W;

    logic [LANES-1:0] lane_hot;
    logic             lane_ok;
    logic             io_hit;
    logic             mem_hit;

    // One detector per byte lane: lane l alone is enabled
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign lane_hot[l] = (bus_be == LANES'(1 << l));
    end

    // Lane legality and lane index (only lane 1 sets the index bit)
    always_comb begin
        lane_ok = |lane_hot;
        lane    = lane_hot[1];
    end

    // Offset from the low address bits with the lane as bit 0
    always_comb ofs = {bus_addr[OFS_W-1:1], lane};

    // Space-specific base compares
    always_comb begin
        io_hit  = (space == SPACE_IO) && !bus_mio &&
                  (bus_addr[IO_W-1:IO_LO] == base);
        mem_hit = (space == SPACE_MEM) && bus_mio &&
                  (bus_addr[ADDR_W-1:MEM_LO] == base) &&
                  (bus_addr[MEM_LO-1:OFS_W] == '0);
    end

    // Final select: right space, right base, one lane, offset in range
    always_comb hit = (io_hit || mem_hit) && lane_ok && (ofs <= BLK_LAST);

endmodule

// File: rtl/relmap_cycle_ctl.sv
// Access sequencer: captures a selected access and counts the wait states.
// Assumes the bus waits for ready before the next strobe; strobes that
// arrive during an access are dropped.
module relmap_cycle_ctl
    import relmap_pkg::*;
#(
    parameter int WAIT_N = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  acc_t acc_in,
    output logic busy,
    output acc_t acc_q,
    output logic rdy
);

    localparam int CNT_W = (WAIT_N > 0) ? $clog2(WAIT_N + 1) : 1;

    // Capture access attributes when an access is accepted
    always_ff @(posedge clk) begin
        if (!rst_n) acc_q <= '0;
        else if (start && !busy) acc_q <= acc_in;
    end

    if (WAIT_N == 0) begin : g_nowait
        // Ready in the first cycle after acceptance
        always_ff @(posedge clk) begin
            if (!rst_n) busy <= 1'b0;
            else if (!busy) busy <= start;
            else busy <= 1'b0;
        end
        assign rdy = busy;
    end else begin : g_wait
        logic [CNT_W-1:0] cnt;
        // Busy flag and wait countdown; ready when the count reaches zero
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                busy <= 1'b0;
                cnt  <= '0;
            end else if (!busy) begin
                busy <= start;
                cnt  <= CNT_W'(WAIT_N);
            end else if (cnt != '0) begin
                cnt <= cnt - 1'b1;
            end else begin
                busy <= 1'b0;
            end
        end
        assign rdy = busy && (cnt == '0);
    end

endmodule

// File: rtl/relmap_decoder.sv
// Top: relocatable register-map decoder.
// Assumes 8-bit slave accesses on lanes 0/1, and that relocation is written
// through the group's own offsets (base at BASE_OFS, space at SPACE_OFS).
module relmap_decoder
    import relmap_pkg::*;
#(
    parameter int          ADDR_W    = 32,
    parameter int          IO_W      = 16,
    parameter int          BASE_W    = 8,
    parameter int          OFS_W     = 8,
    parameter int          WAIT_N    = 2,
    parameter logic [7:0]  BLK_LAST  = 8'hDB,
    parameter logic [7:0]  BASE_OFS  = 8'h7E,
    parameter logic [7:0]  SPACE_OFS = 8'h7F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_ads,
    input  logic              bus_mio,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:1] bus_addr,
    input  logic [1:0]        bus_be,
    input  logic [15:0]       bus_wdata,
    output logic              dec_cs,
    output logic [OFS_W-1:0]  dec_ofs,
    output logic              dec_lane,
    output logic              dec_wr,
    output logic              dec_rdy
);

    logic [BASE_W-1:0] base;
    space_e            space;
    logic              hit;
    logic [OFS_W-1:0]  m_ofs;
    logic              m_lane;
    acc_t              acc_in;
    acc_t              acc_q;
    logic              wr_done;
    logic [BASE_W-1:0] wbyte;

    relmap_addr_match #(
        .ADDR_W(ADDR_W), .IO_W(IO_W), .BASE_W(BASE_W), .OFS_W(OFS_W),
        .LANES(2), .BLK_LAST(BLK_LAST)
    ) match_i (
        .bus_mio (bus_mio),
        .bus_addr(bus_addr),
        .bus_be  (bus_be),
        .base    (base),
        .space   (space),
        .hit     (hit),
        .ofs     (m_ofs),
        .lane    (m_lane)
    );

    // Bundle the attributes of the access being offered
    always_comb acc_in = '{ofs: m_ofs, lane: m_lane, wr: bus_wr};

    relmap_cycle_ctl #(.WAIT_N(WAIT_N)) ctl_i (
        .clk   (clk),
        .rst_n (rst_n),
        .start (bus_ads && hit),
        .acc_in(acc_in),
        .busy  (dec_cs),
        .acc_q (acc_q),
        .rdy   (dec_rdy)
    );

    // Register-file side view of the current access
    always_comb begin
        dec_ofs  = acc_q.ofs;
        dec_lane = acc_q.lane;
        dec_wr   = acc_q.wr;
    end

    // Write completion and byte steering from the active lane
    always_comb begin
        wr_done = dec_rdy && acc_q.wr;
        wbyte   = acc_q.lane ? bus_wdata[15:8] : bus_wdata[7:0];
    end

    relmap_reloc_reg #(.BASE_W(BASE_W)) reloc_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_base (wr_done && (acc_q.ofs == BASE_OFS)),
        .load_space(wr_done && (acc_q.ofs == SPACE_OFS)),
        .wbyte     (wbyte),
        .base      (base),
        .space     (space)
    );

endmodule

// File: rtl/relmap_decoder_chk.sv
// Checker for relmap_decoder, attached by bind. Watches the access
// handshake at the ports; assumes the default two wait states unless
// WAIT_N is overridden.
module relmap_decoder_chk #(
    parameter int         WAIT_N   = 2,
    parameter logic [7:0] BLK_LAST = 8'hDB
) (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_ads,
    input logic       bus_wr,
    input logic       dec_cs,
    input logic [7:0] dec_ofs,
    input logic       dec_wr,
    input logic       dec_rdy
);

    int unsigned wait_seen;

    // Count wait cycles of the current access
    always_ff @(posedge clk) begin
        if (!rst_n) wait_seen <= 0;
        else if (dec_cs && !dec_rdy) wait_seen <= wait_seen + 1;
        else wait_seen <= 0;
    end

    assert_rdy_in_access_R7: assert property (@(posedge clk) disable iff (!rst_n)
        dec_rdy |-> dec_cs);

    assert_wait_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
        dec_rdy |-> wait_seen == WAIT_N);

    assert_ends_after_rdy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        dec_rdy |=> !dec_cs);

    assert_cs_needs_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dec_cs) |-> $past(bus_ads));

    assert_ofs_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_cs && !$rose(dec_cs)) |-> $stable(dec_ofs));

    assert_ofs_in_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
        dec_cs |-> dec_ofs <= BLK_LAST);

    assert_wr_captured_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dec_cs) |-> dec_wr == $past(bus_wr));

endmodule

bind relmap_decoder relmap_decoder_chk #(.WAIT_N(WAIT_N), .BLK_LAST(BLK_LAST)) chk_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .bus_ads(bus_ads),
    .bus_wr (bus_wr),
    .dec_cs (dec_cs),
    .dec_ofs(dec_ofs),
    .dec_wr (dec_wr),
    .dec_rdy(dec_rdy)
);

// File: tb/relmap_decoder_tb_top.sv
// Directed bench for relmap_decoder: one task per scenario.
module relmap_decoder_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_ads = 1'b0;
    logic        bus_mio = 1'b0;
    logic        bus_wr = 1'b0;
    logic [31:0] addr = '0;
    logic [1:0]  bus_be = '0;
    logic [15:0] bus_wdata = '0;
    logic        dec_cs;
    logic [7:0]  dec_ofs;
    logic        dec_lane;
    logic        dec_wr;
    logic        dec_rdy;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    relmap_decoder dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_ads  (bus_ads),
        .bus_mio  (bus_mio),
        .bus_wr   (bus_wr),
        .bus_addr (addr[31:1]),
        .bus_be   (bus_be),
        .bus_wdata(bus_wdata),
        .dec_cs   (dec_cs),
        .dec_ofs  (dec_ofs),
        .dec_lane (dec_lane),
        .dec_wr   (dec_wr),
        .dec_rdy  (dec_rdy)
    );

    // Watchdog: an expired run counts as a failure
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            n_chk = n_chk + 1;
            n_bad = n_bad + 1;
            $display("FAIL watchdog: got %0d cycles expected under 20000", cycles);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk = n_chk + 1;
        if (act !== exp) begin
            n_bad = n_bad + 1;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // One full bus cycle; checks select, offset, lane, write flag and ready timing
    task automatic access(input string tag, input logic mio, input logic [31:0] a,
                          input logic [1:0] be, input logic wr, input logic [15:0] wd,
                          input logic hit, input logic [7:0] ofs);
        @(negedge clk);
        bus_ads = 1'b1; bus_mio = mio; addr = a; bus_be = be;
        bus_wr = wr; bus_wdata = wd;
        @(negedge clk);
        bus_ads = 1'b0;
        chk({tag, " cs"}, 32'(dec_cs), 32'(hit));
        chk({tag, " rdy wait1"}, 32'(dec_rdy), 32'd0);
        if (hit) begin
            chk({tag, " ofs"}, 32'(dec_ofs), 32'(ofs));
            chk({tag, " lane R6"}, 32'(dec_lane), 32'(ofs[0]));
            chk({tag, " wr R10"}, 32'(dec_wr), 32'(wr));
        end
        @(negedge clk);
        chk({tag, " rdy wait2 R7"}, 32'(dec_rdy), 32'd0);
        chk({tag, " cs held R7"}, 32'(dec_cs), 32'(hit));
        @(negedge clk);
        chk({tag, " rdy R7"}, 32'(dec_rdy), 32'(hit));
        @(negedge clk);
        chk({tag, " end R7"}, 32'({dec_cs, dec_rdy}), 32'd0);
    endtask

    task automatic t_reset();
        chk("R1 reset cs", 32'(dec_cs), 32'd0);
        chk("R1 reset rdy", 32'(dec_rdy), 32'd0);
        access("R1 base0 io", 1'b0, 32'h0000_0000, 2'b01, 1'b0, 16'h0, 1'b1, 8'h00);
    endtask

    task automatic t_default_map();
        access("R2 lane1 low", 1'b0, 32'h0000_0000, 2'b10, 1'b0, 16'h0, 1'b1, 8'h01);
        access("R2 last DB", 1'b0, 32'h0000_00DA, 2'b10, 1'b0, 16'h0, 1'b1, 8'hDB);
        access("R2 mid", 1'b0, 32'h0000_0040, 2'b01, 1'b1, 16'h0, 1'b1, 8'h40);
        access("R2 upper ignored", 1'b0, 32'hABCD_0010, 2'b01, 1'b0, 16'h0, 1'b1, 8'h10);
    endtask

    task automatic t_misses();
        access("R3 DC", 1'b0, 32'h0000_00DC, 2'b01, 1'b0, 16'h0, 1'b0, 8'h00);
        access("R3 FF", 1'b0, 32'h0000_00FE, 2'b10, 1'b0, 16'h0, 1'b0, 8'h00);
        access("R4 other base", 1'b0, 32'h0000_0100, 2'b01, 1'b0, 16'h0, 1'b0, 8'h00);
        access("R4 mem in io", 1'b1, 32'h0000_0000, 2'b01, 1'b0, 16'h0, 1'b0, 8'h00);
    endtask

    task automatic t_lanes();
        access("R6 be11", 1'b0, 32'h0000_0010, 2'b11, 1'b0, 16'h0, 1'b0, 8'h00);
        access("R6 be00", 1'b0, 32'h0000_0010, 2'b00, 1'b0, 16'h0, 1'b0, 8'h00);
    endtask

    task automatic t_reloc_io();
        // Writing cycle decodes at the old base 00h
        access("R8 write base", 1'b0, 32'h0000_007E, 2'b01, 1'b1, 16'h0035, 1'b1, 8'h7E);
        access("R8 new io hit", 1'b0, 32'h0000_3510, 2'b01, 1'b0, 16'h0, 1'b1, 8'h10);
        access("R8 old io miss", 1'b0, 32'h0000_0010, 2'b01, 1'b0, 16'h0, 1'b0, 8'h00);
    endtask

    task automatic t_reloc_mem();
        access("R8 write space", 1'b0, 32'h0000_357E, 2'b10, 1'b1, 16'h0100, 1'b1, 8'h7F);
        access("R5 mem hit", 1'b1, 32'h3500_0020, 2'b01, 1'b0, 16'h0, 1'b1, 8'h20);
        access("R5 io miss", 1'b0, 32'h0000_3520, 2'b01, 1'b0, 16'h0, 1'b0, 8'h00);
        access("R5 mid bits set", 1'b1, 32'h3500_0120, 2'b01, 1'b0, 16'h0, 1'b0, 8'h00);
        access("R5 mem DB", 1'b1, 32'h3500_00DA, 2'b10, 1'b0, 16'h0, 1'b1, 8'hDB);
        access("R5 other base", 1'b1, 32'h3600_0000, 2'b01, 1'b0, 16'h0, 1'b0, 8'h00);
    endtask

    task automatic t_strobe_busy();
        @(negedge clk);
        bus_ads = 1'b1; bus_mio = 1'b1; addr = 32'h3500_0030; bus_be = 2'b01; bus_wr = 1'b0;
        @(negedge clk);
        addr = 32'h3500_0050;   // second strobe during the access
        chk("R9 first ofs", 32'(dec_ofs), 32'h30);
        @(negedge clk);
        bus_ads = 1'b0;
        chk("R9 ofs kept", 32'(dec_ofs), 32'h30);
        @(negedge clk);
        chk("R9 rdy", 32'(dec_rdy), 32'd1);
        @(negedge clk);
        chk("R9 no restart", 32'({dec_cs, dec_rdy}), 32'd0);
    endtask

    task automatic t_back_to_io();
        access("R8 space io", 1'b1, 32'h3500_007E, 2'b10, 1'b1, 16'h0000, 1'b1, 8'h7F);
        access("R8 io at 35", 1'b0, 32'h0000_3500, 2'b01, 1'b0, 16'h0, 1'b1, 8'h00);
        access("R8 base zero", 1'b0, 32'h0000_357E, 2'b01, 1'b1, 16'hFF00, 1'b1, 8'h7E);
        access("R8 default back", 1'b0, 32'h0000_0000, 2'b01, 1'b0, 16'h0, 1'b1, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_default_map();
        t_misses();
        t_lanes();
        t_reloc_io();
        t_reloc_mem();
        t_strobe_busy();
        t_back_to_io();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule